// File: doc/BRIEF.md
# Burst Demodulator Carrier Recovery Loop

This block recovers the carrier for a low-IF QPSK burst demodulator. A 24-bit phase accumulator addresses a small quarter-wave sine table. Each real A/D sample, taken at eight times the symbol rate, is multiplied by the resulting cosine and negated sine, which gives the I and Q mixer products. After the external matched filters, one detection sample pair per symbol returns on a strobe. A decision-directed detector turns each pair into a phase error. A proportional-plus-integral filter then steers the oscillator step away from a programmable centre frequency. Both gains of that filter are plain left shifts.

At the start of a burst the loop is held open while the acquisition logic works on the preamble. A single load strobe then writes the oscillator phase and the integrator from the external estimates, and the loop is closed for tracking. The integrator is always visible as a frequency error word, so the terminal can correct its uplink frequency. The filter sum that drives the oscillator is also brought out so its value can be observed.

Top module: `carrier_loop`

## Requirements
- R1: After reset, mix_i, mix_q, mix_vld, freq_err and loop_word are all zero, and the oscillator phase is zero.
- R2: One cycle after sample_vld is high, mix_vld is high, mix_i = x*C(p) and mix_q = -x*S(p). Here x is the sample and p is the phase before that sample's update. Quadrant q is p[23:22] and index k is p[21:18]. With T(m) = (127*m*(32-m)+128)/256 in integer division, |S| is T(k) for even q and T(16-k) for odd q, and S is negative for q of 2 or 3. C(p) = S(p + 0x400000). The mixer outputs hold when sample_vld is low, and mix_vld is low one cycle after sample_vld is low.
- R3: On each sample_vld the phase advances, modulo 2^24, by nom_freq plus loop_word sign-extended to 24 bits. The phase holds when sample_vld is low.
- R4: est_load sets the phase to est_phase and the integrator to est_freq in the same cycle, and clears the proportional term. It takes priority over sample and loop updates.
- R5: On det_stb the detector forms e = sgn(det_i)*det_q - sgn(det_q)*det_i, with sgn(0) = +1. It is registered and applied to the filter one cycle later.
- R6: When e is applied with loop_en high, the integrator becomes the sum of itself and e*2^ki_shift, saturated to the signed 20-bit range. The integrator does not change when no error is applied.
- R7: When e is applied with loop_en high, the proportional term becomes e*2^kp_shift saturated to 20 bits, and it holds until the next strobe. loop_word (21-bit signed) = integrator + proportional term.
- R8: With loop_en low, strobes leave the integrator unchanged and the proportional term is zero one cycle later, so loop_word equals freq_err.
- R9: freq_err always shows the integrator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_sample | input | 8 | Signed real low-IF sample |
| sample_vld | input | 1 | Sample strobe (8x symbol rate) |
| mix_i | output | 16 | Signed in-phase mixer product |
| mix_q | output | 16 | Signed quadrature mixer product |
| mix_vld | output | 1 | Mixer products valid |
| det_i | input | 8 | Signed I detection sample |
| det_q | input | 8 | Signed Q detection sample |
| det_stb | input | 1 | Detection strobe, once per symbol |
| nom_freq | input | 24 | Centre frequency step |
| kp_shift | input | 4 | Proportional left-shift amount |
| ki_shift | input | 4 | Integral left-shift amount |
| loop_en | input | 1 | 1 closes the loop, 0 holds it open |
| est_load | input | 1 | Load acquisition estimates |
| est_phase | input | 24 | Phase estimate |
| est_freq | input | 20 | Signed frequency estimate for the integrator |
| freq_err | output | 20 | Signed integrator (frequency error) |
| loop_word | output | 21 | Signed loop filter sum |

## Verification
The hardest case to reach is integrator saturation. From a random walk of detector errors it would take a very long series of same-sign strobes. The stimulus reaches it by loading an estimate a few counts below each rail and then applying a large error with the largest integral shift. The boundary detector inputs with a zero component are driven directly, because random values rarely produce them. The phase is checked through the mixer outputs: known loads put it on the quadrant boundaries, and random loads cover the table folding.

// File: rtl/carrier_loop_pkg.sv
package carrier_loop_pkg;
  // Quarter-wave amplitude: parabolic fit of a sine over one quadrant,
  // index m in 0..n, peak amp at m = n, rounded to nearest.
  function automatic int qw_amp(int m, int n, int amp);
    return (amp * m * (2 * n - m) + (n * n) / 2) / (n * n);
  endfunction
endpackage

// File: rtl/cl_nco.sv
module cl_nco #(
  parameter int PH_W  = 24,
  parameter int IN_W  = 8,
  parameter int TBL_W = 8,
  parameter int QW_AW = 4,
  parameter int LW_W  = 21
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic signed [IN_W-1:0]      if_sample,
  input  logic                        sample_vld,
  input  logic [PH_W-1:0]             nom_freq,
  input  logic signed [LW_W-1:0]      loop_word,
  input  logic                        est_load,
  input  logic [PH_W-1:0]             est_phase,
  output logic signed [IN_W+TBL_W-1:0] mix_i,
  output logic signed [IN_W+TBL_W-1:0] mix_q,
  output logic                        mix_vld
);
  localparam int N     = 1 << QW_AW;
  localparam int AMP   = (1 << (TBL_W - 1)) - 1;
  localparam int MIX_W = IN_W + TBL_W;

  logic signed [TBL_W-1:0] qw_tbl [N+1];

  for (genvar m = 0; m <= N; m++) begin : g_tbl
    assign qw_tbl[m] = TBL_W'(carrier_loop_pkg::qw_amp(m, N, AMP));
  end

  logic [PH_W-1:0]          phase_r, phase_d, step;
  logic [1:0]               quad_s, quad_c;
  logic [QW_AW:0]           idx, mir;
  logic signed [TBL_W-1:0]  mag_s, mag_c, sin_v, cos_v;
  logic signed [MIX_W-1:0]  mi_d, mq_d, prod_s;

  always_comb begin
    quad_s = phase_r[PH_W-1 -: 2];
    quad_c = quad_s + 2'd1;
    idx    = {1'b0, phase_r[PH_W-3 -: QW_AW]};
    mir    = (QW_AW+1)'(N) - idx;
    mag_s  = quad_s[0] ? qw_tbl[mir] : qw_tbl[idx];
    mag_c  = quad_c[0] ? qw_tbl[mir] : qw_tbl[idx];
    sin_v  = quad_s[1] ? -mag_s : mag_s;
    cos_v  = quad_c[1] ? -mag_c : mag_c;
    step   = nom_freq + {{(PH_W-LW_W){loop_word[LW_W-1]}}, loop_word};
    prod_s = MIX_W'(if_sample) * MIX_W'(sin_v);
    mi_d   = MIX_W'(if_sample) * MIX_W'(cos_v);
    mq_d   = -prod_s;
    if (est_load)        phase_d = est_phase;
    else if (sample_vld) phase_d = phase_r + step;
    else                 phase_d = phase_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r <= '0;
      mix_i   <= '0;
      mix_q   <= '0;
      mix_vld <= 1'b0;
    end else begin
      phase_r <= phase_d;
      mix_vld <= sample_vld;
      if (sample_vld) begin
        mix_i <= mi_d;
        mix_q <= mq_d;
      end
    end
  end
endmodule

// File: rtl/cl_phase_det.sv
module cl_phase_det #(
  parameter int DET_W = 8,
  parameter int PE_W  = DET_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [DET_W-1:0] det_i,
  input  logic signed [DET_W-1:0] det_q,
  input  logic                    det_stb,
  output logic signed [PE_W-1:0]  pe,
  output logic                    pe_vld
);
  logic signed [PE_W-1:0] ti, tq, pe_d;

  always_comb begin
    // sign of zero counts as positive
    tq   = det_i[DET_W-1] ? -PE_W'(det_q) : PE_W'(det_q);
    ti   = det_q[DET_W-1] ? -PE_W'(det_i) : PE_W'(det_i);
    pe_d = det_stb ? (tq - ti) : pe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe     <= '0;
      pe_vld <= 1'b0;
    end else begin
      pe     <= pe_d;
      pe_vld <= det_stb;
    end
  end
endmodule

// File: rtl/cl_loop_filter.sv
module cl_loop_filter #(
  parameter int PE_W  = 10,
  parameter int ACC_W = 20,
  parameter int SH_W  = 4,
  parameter int LW_W  = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PE_W-1:0]  pe,
  input  logic                    pe_vld,
  input  logic                    loop_en,
  input  logic [SH_W-1:0]         kp_shift,
  input  logic [SH_W-1:0]         ki_shift,
  input  logic                    est_load,
  input  logic signed [ACC_W-1:0] est_freq,
  output logic signed [ACC_W-1:0] integ,
  output logic signed [LW_W-1:0]  loop_word
);
  localparam int SPAN = PE_W + (1 << SH_W);
  localparam int WIDE = (SPAN > ACC_W) ? SPAN + 1 : ACC_W + 1;
  localparam logic signed [WIDE-1:0] ACC_MAX =
    {{(WIDE-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] ACC_MIN =
    {{(WIDE-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] clip(logic signed [WIDE-1:0] v);
    if (v > ACC_MAX)      return ACC_MAX[ACC_W-1:0];
    else if (v < ACC_MIN) return ACC_MIN[ACC_W-1:0];
    else                  return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] prop_r, prop_d, integ_d;
  logic signed [WIDE-1:0]  inc_i, inc_p, sum_i;

  always_comb begin
    inc_i = WIDE'(pe) <<< ki_shift;
    inc_p = WIDE'(pe) <<< kp_shift;
    sum_i = WIDE'(integ) + inc_i;
    if (est_load)                integ_d = est_freq;
    else if (loop_en && pe_vld)  integ_d = clip(sum_i);
    else                         integ_d = integ;
    if (est_load || !loop_en)    prop_d = '0;
    else if (pe_vld)             prop_d = clip(inc_p);
    else                         prop_d = prop_r;
    loop_word = LW_W'(integ) + LW_W'(prop_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ  <= '0;
      prop_r <= '0;
    end else begin
      integ  <= integ_d;
      prop_r <= prop_d;
    end
  end
endmodule

// File: rtl/carrier_loop.sv
module carrier_loop #(
  parameter int IN_W  = 8,
  parameter int DET_W = 8,
  parameter int PH_W  = 24,
  parameter int ACC_W = 20,
  parameter int TBL_W = 8,
  parameter int QW_AW = 4,
  parameter int SH_W  = 4,
  localparam int MIX_W = IN_W + TBL_W,
  localparam int LW_W  = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  if_sample,
  input  logic                    sample_vld,
  output logic signed [MIX_W-1:0] mix_i,
  output logic signed [MIX_W-1:0] mix_q,
  output logic                    mix_vld,
  input  logic signed [DET_W-1:0] det_i,
  input  logic signed [DET_W-1:0] det_q,
  input  logic                    det_stb,
  input  logic [PH_W-1:0]         nom_freq,
  input  logic [SH_W-1:0]         kp_shift,
  input  logic [SH_W-1:0]         ki_shift,
  input  logic                    loop_en,
  input  logic                    est_load,
  input  logic [PH_W-1:0]         est_phase,
  input  logic signed [ACC_W-1:0] est_freq,
  output logic signed [ACC_W-1:0] freq_err,
  output logic signed [LW_W-1:0]  loop_word
);
  localparam int PE_W = DET_W + 2;

  logic signed [PE_W-1:0] pe;
  logic                   pe_vld;

  cl_nco #(
    .PH_W(PH_W), .IN_W(IN_W), .TBL_W(TBL_W), .QW_AW(QW_AW), .LW_W(LW_W)
  ) u_nco (
    .clk(clk), .rst_n(rst_n), .if_sample(if_sample), .sample_vld(sample_vld),
    .nom_freq(nom_freq), .loop_word(loop_word), .est_load(est_load),
    .est_phase(est_phase), .mix_i(mix_i), .mix_q(mix_q), .mix_vld(mix_vld)
  );

  cl_phase_det #(.DET_W(DET_W), .PE_W(PE_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .det_i(det_i), .det_q(det_q),
    .det_stb(det_stb), .pe(pe), .pe_vld(pe_vld)
  );

  cl_loop_filter #(
    .PE_W(PE_W), .ACC_W(ACC_W), .SH_W(SH_W), .LW_W(LW_W)
  ) u_lf (
    .clk(clk), .rst_n(rst_n), .pe(pe), .pe_vld(pe_vld), .loop_en(loop_en),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .est_load(est_load),
    .est_freq(est_freq), .integ(freq_err), .loop_word(loop_word)
  );
endmodule

// File: rtl/carrier_loop_chk.sv
module carrier_loop_chk #(
  parameter int ACC_W = 20,
  parameter int LW_W  = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_vld,
  input logic                    mix_vld,
  input logic                    det_stb,
  input logic                    est_load,
  input logic                    loop_en,
  input logic signed [ACC_W-1:0] est_freq,
  input logic signed [ACC_W-1:0] freq_err,
  input logic signed [LW_W-1:0]  loop_word
);
  // R2
  mix_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> mix_vld);
  // R2
  mix_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !mix_vld);
  // R4
  est_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_load |=> (freq_err == $past(est_freq)));
  // R8
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !est_load) |=> $stable(freq_err));
  // R8
  open_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (loop_word == {freq_err[ACC_W-1], freq_err}));
  // R6
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_stb && !est_load) ##1 !est_load |=> $stable(freq_err));
endmodule

bind carrier_loop carrier_loop_chk #(.ACC_W(ACC_W), .LW_W(LW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .mix_vld(mix_vld),
  .det_stb(det_stb), .est_load(est_load), .loop_en(loop_en),
  .est_freq(est_freq), .freq_err(freq_err), .loop_word(loop_word)
);

// File: tb/sim_carrier_loop.sv
module sim_carrier_loop;
  localparam longint AMAX = 524287;
  localparam longint AMIN = -524288;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [7:0]  if_sample = '0;
  logic               sample_vld = 1'b0;
  logic signed [15:0] mix_i, mix_q;
  logic               mix_vld;
  logic signed [7:0]  det_i = '0, det_q = '0;
  logic               det_stb = 1'b0;
  logic [23:0]        nom_freq = '0;
  logic [3:0]         kp_shift = '0, ki_shift = '0;
  logic               loop_en = 1'b0;
  logic               est_load = 1'b0;
  logic [23:0]        est_phase = '0;
  logic signed [19:0] est_freq = '0;
  logic signed [19:0] freq_err;
  logic signed [20:0] loop_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] m_phase = '0;
  longint m_integ = 0, m_prop = 0;

  always #10 clk = ~clk;

  carrier_loop u0 (
    .clk(clk), .rst_n(rst_n), .if_sample(if_sample), .sample_vld(sample_vld),
    .mix_i(mix_i), .mix_q(mix_q), .mix_vld(mix_vld), .det_i(det_i),
    .det_q(det_q), .det_stb(det_stb), .nom_freq(nom_freq),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .loop_en(loop_en),
    .est_load(est_load), .est_phase(est_phase), .est_freq(est_freq),
    .freq_err(freq_err), .loop_word(loop_word)
  );

  function automatic longint tq(int m);
    return (127 * m * (32 - m) + 128) / 256;
  endfunction

  function automatic longint sin_m(logic [23:0] p);
    longint mag;
    mag = p[22] ? tq(16 - int'(p[21:18])) : tq(int'(p[21:18]));
    return p[23] ? -mag : mag;
  endfunction

  function automatic longint cos_m(logic [23:0] p);
    return sin_m(p + 24'h400000);
  endfunction

  function automatic longint pd(longint i, longint q);
    longint si, sq;
    si = (i < 0) ? -1 : 1;
    sq = (q < 0) ? -1 : 1;
    return si * q - sq * i;
  endfunction

  function automatic longint clip(longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic do_load(logic [23:0] ph, longint fr);
    est_phase = ph; est_freq = 20'(fr); est_load = 1'b1;
    @(negedge clk);
    est_load = 1'b0;
    m_phase = ph; m_integ = fr; m_prop = 0;
    chk("R4 freq_err after load", freq_err, fr);
    chk("R4 loop_word after load", loop_word, fr);
  endtask

  task automatic do_sample(string tag, longint x);
    longint lw;
    if_sample = 8'(x); sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    chk({tag, " mix_vld"}, mix_vld, 1);
    chk({tag, " mix_i"}, mix_i, x * cos_m(m_phase));
    chk({tag, " mix_q"}, mix_q, -x * sin_m(m_phase));
    lw = m_integ + m_prop;
    m_phase = m_phase + nom_freq + 24'(lw);
    @(negedge clk);
    chk("R2 mix_vld low", mix_vld, 0);
  endtask

  task automatic do_strobe(string tag, longint i, longint q);
    longint e;
    det_i = 8'(i); det_q = 8'(q); det_stb = 1'b1;
    @(negedge clk);
    det_stb = 1'b0;
    @(negedge clk);
    e = pd(i, q);
    if (loop_en) begin
      m_integ = clip(m_integ + e * (longint'(1) << ki_shift));
      m_prop = clip(e * (longint'(1) << kp_shift));
    end else begin
      m_prop = 0;
    end
    chk({tag, " R9 freq_err"}, freq_err, m_integ);
    chk({tag, " R7 loop_word"}, loop_word, m_integ + m_prop);
  endtask

  task automatic set_cfg(bit en, int kp, int ki, logic [23:0] nf);
    loop_en = en; kp_shift = 4'(kp); ki_shift = 4'(ki); nom_freq = nf;
    @(negedge clk);
    if (!en) m_prop = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1f3a5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mix_i", mix_i, 0);
    chk("R1 mix_q", mix_q, 0);
    chk("R1 mix_vld", mix_vld, 0);
    chk("R1 freq_err", freq_err, 0);
    chk("R1 loop_word", loop_word, 0);
    do_sample("R1 R2 phase zero", 50);

    // R3 quarter step, loop open: 0, 90, 180, 270 degrees
    set_cfg(0, 0, 0, 24'h400000);
    do_load(24'h000000, 0);
    do_sample("R3 R2 q0", 50);
    do_sample("R3 R2 q1", 50);
    do_sample("R3 R2 q2", 50);
    do_sample("R3 R2 q3", -128);
    chk("R2 explicit cos at 0", 50 * cos_m(24'h0), 6350);

    // R5 detector corners including zero components
    set_cfg(1, 0, 0, 24'h0);
    do_load(24'h0, 0);
    do_strobe("R5 I0", 0, 50);
    do_strobe("R5 Q0", -40, 0);
    do_strobe("R5 neg", 10, -100);
    do_strobe("R5 both min", -128, -128);

    // R6 saturation at both rails
    set_cfg(1, 15, 15, 24'h0);
    do_load(24'h123456, AMAX - 10);
    do_strobe("R6 sat high", 10, 100);
    chk("R6 rail high", freq_err, AMAX);
    do_load(24'h0, AMIN + 10);
    do_strobe("R6 sat low", 10, -100);
    chk("R6 rail low", freq_err, AMIN);

    // R8 open loop ignores strobes
    set_cfg(1, 3, 2, 24'h0);
    do_load(24'h0, 1000);
    do_strobe("R7 closed", 10, 100);
    set_cfg(0, 3, 2, 24'h0);
    chk("R8 prop cleared", loop_word, m_integ);
    do_strobe("R8 open", 10, 100);
    chk("R8 integ held", freq_err, 1000 + 90 * 4);

    // random mix of operations
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4)
        do_sample("R2 R3 rnd", longint'($signed(8'($urandom))));
      else if (op < 7)
        do_strobe("R6 rnd", longint'($signed(8'($urandom))),
                  longint'($signed(8'($urandom))));
      else if (op < 8)
        do_load(24'($urandom), longint'($signed(20'($urandom))));
      else
        set_cfg(bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 15)), 24'($urandom));
    end
    finish_run();
  end
endmodule